// File: doc/BRIEF.md
# Random-Byte Peripheral Register Port

This block puts a random-byte source behind one 32-bit word on a simple memory-mapped bus. Software sets an enable bit in that word. The enable goes out to the source as a run signal, and byte capture starts. The source delivers bytes on a data bus with a one-cycle strobe. The block keeps the newest byte and raises a sticky valid flag. Software polls the same word: it sees the flag and the byte together, and any read clears the flag.

The block has no reset of its own for the capture path. Clearing the enable bit empties the captured byte and drops the flag, and strobes that arrive while the bit is low are dropped. The system reset only brings every register to its idle value at power-up. Bus accesses are acknowledged one clock after their strobe. Addresses other than the register's word return no acknowledge and zero data.

Top module: `rand_byte_port`

## Requirements
- R1: After reset the enable output is 0, the acknowledge is 0, the read data is 0, and the first read of the register returns 0x00000000.
- R2: The register answers when address bits 31:2 match those of 0xFFFFFFB8, so all four byte offsets of that word hit. Any other address gives no acknowledge, read data 0, and no change to the register.
- R3: Bit 30 is the enable. A write sets it to the value of write-data bit 30, a read returns it in bit 30, and the `src_run` output follows it.
- R4: While enabled, a strobe on `src_stb` captures `src_byte`. The next read returns that byte in bits 7:0 with bit 31 (valid) set.
- R5: A newer byte overwrites an unread one, and the following read returns only the newest byte.
- R6: Any read of the register clears the valid flag. A second read with no new strobe returns the same byte with bit 31 at 0.
- R7: While enable is 0, strobes are ignored, and the valid flag and the captured byte are both cleared to 0. After the bit is set again, a read with no new strobe returns 0x40000000.
- R8: Bits 29:8 always read 0. Writes to bits 31 and 7:0 have no effect.
- R9: When a strobe and a read of the register fall in the same cycle, the read returns the previous byte with valid set. The new byte stays flagged valid for the next read.
- R10: Read data and acknowledge appear one clock after the read strobe. A write gets its acknowledge one clock after its strobe, and the write takes effect on the clock edge of the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high after a read |
| bus_ack | output | 1 | Acknowledge, one clock after a strobe that hits the register |
| src_byte | input | 8 | Byte from the random source |
| src_stb | input | 1 | Strobe marking a new byte on src_byte |
| src_run | output | 1 | Enable to the random source |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 32-bit word and base address 0xFFFFFFB8. The byte field is small, so all 256 byte values are pushed through the capture path in turn. Each value is checked with a fresh read and then a repeat read, which covers capture, the valid flag and clear-on-read for every value. A sweep of addresses from eight bytes below the base to eleven bytes above it checks the decode boundary on both sides. Targeted sequences cover disable-then-re-enable, overwrite of an unread byte, writes to the read-only bits, and a strobe landing in the same cycle as a read.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned VALID_POS = 31;
  localparam int unsigned RUN_POS   = 30;
endpackage

// File: rtl/rbp_addr_match.sv
module rbp_addr_match #(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        OFS_BITS  = 2,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'hFFFF_FFB8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit
);
  localparam int unsigned TAG_W = ADDR_W - OFS_BITS;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:OFS_BITS];

  logic match;

  always_comb begin
    match  = (addr[ADDR_W-1:OFS_BITS] == BASE_TAG);
    rd_hit = match & rd;
    wr_hit = match & wr;
  end
endmodule

// File: rtl/rbp_enable_reg.sv
module rbp_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_run,
  output logic run
);
  logic run_q, run_d;

  always_comb begin
    run_d = wr_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_hit) begin
      run_q <= run_d;
    end
  end

  assign run = run_q;

  // R3: a hit write loads the enable, nothing else moves it
  p_run_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (run == $past(wr_run)));
  p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(run));
endmodule

// File: rtl/rbp_capture.sv
module rbp_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stb,
  input  logic [BYTE_W-1:0] din,
  input  logic              rd_hit,
  output logic [BYTE_W-1:0] held,
  output logic              fresh
);
  logic [BYTE_W-1:0] held_q, held_d;
  logic              fresh_q, fresh_d;
  logic              upd_en;

  always_comb begin
    held_d  = held_q;
    fresh_d = fresh_q;
    upd_en  = 1'b0;
    if (!run) begin
      held_d  = '0;
      fresh_d = 1'b0;
      upd_en  = 1'b1;
    end else if (stb) begin
      held_d  = din;
      fresh_d = 1'b1;
      upd_en  = 1'b1;
    end else if (rd_hit) begin
      fresh_d = 1'b0;
      upd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      fresh_q <= 1'b0;
    end else if (upd_en) begin
      held_q  <= held_d;
      fresh_q <= fresh_d;
    end
  end

  assign held  = held_q;
  assign fresh = fresh_q;

  p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!fresh && held == '0));
  p_take_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb) |=> (fresh && held == $past(din)));
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stb && rd_hit) |=> !fresh);
  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stb) |=> $stable(held));
endmodule

// File: rtl/rbp_read_port.sv
module rbp_read_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_hit,
  input  logic                       wr_hit,
  input  logic                       run,
  input  logic                       fresh,
  input  logic [BYTE_W-1:0]          held,
  output logic [rbp_pkg::WORD_W-1:0] rdata,
  output logic                       ack
);
  import rbp_pkg::*;

  logic [WORD_W-1:0] word, rdata_q, rdata_d;
  logic              ack_q, ack_d;

  always_comb begin
    word                 = '0;
    word[BYTE_W-1:0]     = held;
    word[RUN_POS]        = run;
    word[VALID_POS]      = fresh;
    rdata_d              = rd_hit ? word : '0;
    ack_d                = rd_hit | wr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
    end
  end

  assign rdata = rdata_q;
  assign ack   = ack_q;

  p_ack_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit || wr_hit) |=> ack);
  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit || wr_hit) |=> (!ack && rdata == '0));
  p_rd_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rdata[VALID_POS] == $past(fresh) && rdata[BYTE_W-1:0] == $past(held)));
endmodule

// File: rtl/rand_byte_port.sv
module rand_byte_port #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FFB8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [rbp_pkg::WORD_W-1:0] bus_wdata,
  output logic [rbp_pkg::WORD_W-1:0] bus_rdata,
  output logic                       bus_ack,
  input  logic [BYTE_W-1:0]          src_byte,
  input  logic                       src_stb,
  output logic                       src_run
);
  import rbp_pkg::*;

  localparam int unsigned OFS_BITS = $clog2(WORD_W / 8);

  logic              rd_hit, wr_hit, run, fresh;
  logic [BYTE_W-1:0] held;

  rbp_addr_match #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .BASE_ADDR(BASE_ADDR)) u_match (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  rbp_enable_reg u_enable (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_run(bus_wdata[RUN_POS]), .run(run)
  );

  rbp_capture #(.BYTE_W(BYTE_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .run(run), .stb(src_stb), .din(src_byte),
    .rd_hit(rd_hit), .held(held), .fresh(fresh)
  );

  rbp_read_port #(.BYTE_W(BYTE_W)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit), .run(run),
    .fresh(fresh), .held(held), .rdata(bus_rdata), .ack(bus_ack)
  );

  assign src_run = run;

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (bus_rdata[RUN_POS-1:BYTE_W] == '0));
endmodule

// File: tb/tb_rand_byte_port.sv
module tb_rand_byte_port;
  localparam logic [31:0] BASE = 32'hFFFF_FFB8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  src_byte = '0;
  logic        src_stb = 1'b0;
  logic        src_run;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rand_byte_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .src_byte(src_byte), .src_stb(src_stb), .src_run(src_run)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic k);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; k = bus_ack;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v, output logic k);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    k = bus_ack;
    bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    src_byte = b; src_stb = 1'b1;
    @(negedge clk);
    src_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        k;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    check("R1 ack in reset", {31'b0, bus_ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 src_run after reset", {31'b0, src_run}, 32'h0);
    rd(BASE, d, k);
    check("R1 first read", d, 32'h0);
    check("R10 read ack", {31'b0, k}, 32'h1);

    // strobes before enable are dropped
    push(8'h5A);
    rd(BASE, d, k);
    check("R7 strobe while disabled", d, 32'h0);

    wr(BASE, 32'h4000_0000, k);
    check("R10 write ack", {31'b0, k}, 32'h1);
    check("R3 src_run after write edge", {31'b0, src_run}, 32'h1);
    rd(BASE, d, k);
    check("R3 enable readback", d, 32'h4000_0000);

    // exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      push(v[7:0]);
      rd(BASE, d, k);
      check("R4 capture", d, 32'hC000_0000 | v);
      rd(BASE, d, k);
      check("R6 valid cleared", d, 32'h4000_0000 | v);
    end

    push(8'h12); push(8'h34);
    rd(BASE, d, k);
    check("R5 overwrite", d, 32'hC000_0034);

    // same-cycle strobe and read
    push(8'hA1);
    @(negedge clk);
    bus_addr = BASE; bus_rd = 1'b1; src_byte = 8'hB2; src_stb = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0; src_stb = 1'b0;
    check("R9 collision returns old", d, 32'hC000_00A1);
    rd(BASE, d, k);
    check("R9 new byte still valid", d, 32'hC000_00B2);
    rd(BASE, d, k);
    check("R6 cleared after collision", d, 32'h4000_00B2);

    // read-only fields and unused bits
    wr(BASE, 32'hFFFF_FFFF, k);
    rd(BASE, d, k);
    check("R8 read-only writes ignored", d, 32'h4000_00B2);
    wr(BASE + 32'd3, 32'hBFFF_FF00 | 32'h4000_0000, k);
    rd(BASE + 32'd2, d, k);
    check("R8 unused bits zero", d & 32'h3FFF_FF00, 32'h0);

    // disable clears state
    push(8'h3C);
    wr(BASE, 32'h0, k);
    check("R3 src_run low", {31'b0, src_run}, 32'h0);
    rd(BASE, d, k);
    check("R7 disabled read", d, 32'h0);
    push(8'h77);
    wr(BASE, 32'h4000_0000, k);
    rd(BASE, d, k);
    check("R7 re-enable cleared", d, 32'h4000_0000);

    // address decode sweep
    for (int off = -8; off < 12; off++) begin
      logic [31:0] a;
      a = BASE + off;
      if (a[31:2] == BASE[31:2]) begin
        rd(a, d, k);
        check("R2 hit ack", {31'b0, k}, 32'h1);
        check("R2 hit data", d, 32'h4000_0000);
      end else begin
        rd(a, d, k);
        check("R2 miss ack", {31'b0, k}, 32'h0);
        check("R2 miss data", d, 32'h0);
        wr(a, 32'h0, k);
        check("R2 miss write ack", {31'b0, k}, 32'h0);
        rd(BASE, d, k);
        check("R2 miss write no effect", d, 32'h4000_0000);
      end
    end

    finish_run();
  end
endmodule